// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Bank

This block watches eight external event lines and raises a single combined interrupt when any enabled line meets its programmed trigger condition. Each line passes through a two-flop synchronizer into the bus clock domain. A sampling strobe, derived from the bus clock by a programmable divider (`SMP_DIV`), then captures the line into a sampled-level register. With a divider of 1 every bus cycle is a sample. Larger values give a slower sampling rate, such as a low-frequency wake-up sampler.

Three independent control bits per line select the trigger. The level bit picks level versus edge sensing. The any-edge bit makes an edge-sensed line fire on every transition. The polarity bit picks high/rising versus low/falling. Together these give five trigger types. Software accesses the block through a 32-bit word register window: it enables lines, reads raw and enabled status, acknowledges edge events and reads the current sampled levels.

Top module: `irq_sense_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every register reads 0 and `irq_out` is 0.
- R2: The word at byte offset 0x1C returns the sampled line levels in bits 7:0. A level change on `evt_in` becomes visible there after the two synchronizer stages plus the next sampling strobe.
- R3: When the level bit (0x10) is 0, the any-edge bit (0x14) is 0 and the polarity bit (0x18) is 1, a low-to-high change between two consecutive samples sets that line's raw status bit (0x04). The bit stays set until it is acknowledged.
- R4: With the level bit 0, the any-edge bit 0 and the polarity bit 0, only a high-to-low change between samples sets the raw status bit.
- R5: With the level bit 0 and the any-edge bit 1, any change between samples sets the raw status bit, whatever the polarity bit holds.
- R6: Writing a 1 to bit i at offset 0x0C clears raw bit i of an edge-sensed line. Writing a 0 there leaves that bit unchanged. Offset 0x0C always reads 0.
- R7: If a qualifying edge is sampled in the same cycle as the clear write for that line, the raw bit remains set.
- R8: With the level bit 1, the raw bit equals (sampled level == polarity bit), one cycle after the sample. The clear write has no effect on it.
- R9: Offset 0x08 reads raw status AND the enable register (0x00).
- R10: `irq_out` is 1 exactly when any bit of the enabled status is 1.
- R11: Samples are taken only on every `SMP_DIV`-th cycle after reset. The sampled level holds between strobes, so a pulse that falls between two strobes produces no event.
- R12: Offsets 0x00, 0x10, 0x14 and 0x18 are read/write in bits 7:0, and bits 31:8 of every offset read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 8 | Asynchronous event lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register word (bits 4:2 decode) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt |

## Verification
A wrong sampled level shows at offset 0x1C in the cycle after the bad strobe. It also shows one strobe later as a spurious or missing raw bit at 0x04, and `irq_out` mirrors that bit in the same cycle when the line is enabled. A wrong raw bit on an edge-sensed line persists until it is acknowledged, so it stays visible for many cycles. A wrong raw bit on a level-sensed line is corrected one cycle after the sample changes, so the bench compares every register and `irq_out` on every cycle and does not rely on occasional reads. Clears are issued while the lines toggle, so edge-versus-clear collisions occur on strobe cycles and off them.

// File: rtl/eib_pkg.sv
package eib_pkg;

    // register word select, bus_addr[4:2]
    typedef enum logic [2:0] {
        RG_EN   = 3'd0,
        RG_RAW  = 3'd1,
        RG_ACT  = 3'd2,
        RG_ACK  = 3'd3,
        RG_LVL  = 3'd4,
        RG_ANY  = 3'd5,
        RG_POL  = 3'd6,
        RG_SMP  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic lvl;   // 1: level sensed, 0: edge sensed
        logic any;   // edge sensed: fire on both directions
        logic pol;   // 1: rising/high, 0: falling/low
    } trig_cfg_t;

    function automatic logic edge_hit(trig_cfg_t c, logic now_v, logic old_v);
        if (c.any)
            return now_v ^ old_v;
        else if (c.pol)
            return now_v & ~old_v;
        else
            return ~now_v & old_v;
    endfunction

    function automatic logic level_hit(trig_cfg_t c, logic lvl_v);
        return lvl_v == c.pol;
    endfunction

endpackage

// File: rtl/eib_sync.sv
module eib_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign d_sync = stab_q;
endmodule

// File: rtl/eib_sampler.sv
module eib_sampler #(
    parameter int W       = 8,
    parameter int SMP_DIV = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_sync,
    output logic         tick,
    output logic [W-1:0] cur
);
    localparam int CW = (SMP_DIV > 1) ? $clog2(SMP_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SMP_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  cur_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cur_q <= '0;
        end else begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (tick)
                cur_q <= in_sync;
        end
    end

    assign cur = cur_q;

    // R11: sampled level only moves on a strobe
    a_r11_hold_between: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cur_q));

    generate
        if (SMP_DIV > 1) begin : g_slow
            a_r11_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/eib_chan.sv
module eib_chan
    import eib_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_cfg_t cfg,
    input  logic      tick,
    input  logic      smp_new,
    input  logic      smp_cur,
    input  logic      clr,
    output logic      raw
);
    logic ev;
    logic lvl_on;
    logic raw_q;

    assign ev     = tick & edge_hit(cfg, smp_new, smp_cur);
    assign lvl_on = level_hit(cfg, smp_cur);

    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= 1'b0;
        else if (cfg.lvl)
            raw_q <= lvl_on;
        else
            raw_q <= ev | (raw_q & ~clr);
    end

    assign raw = raw_q;

    // R7: an edge in the clear cycle keeps the bit set
    a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (!cfg.lvl && ev) |=> raw_q);

    // R6: clear without a competing edge empties the bit
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (!cfg.lvl && clr && !ev) |=> !raw_q);

    // R8: active level cannot be acknowledged away
    a_r8_level_holds: assert property (@(posedge clk) disable iff (rst)
        (cfg.lvl && lvl_on) |=> raw_q);

    // R3: edge-sensed bit rises only on a qualifying sampled edge
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!cfg.lvl && !ev) |=> !$rose(raw_q));
endmodule

// File: rtl/eib_regs.sv
module eib_regs
    import eib_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  reg_sel_e            sel,
    input  logic [DW-1:0]       wdata,
    output logic [N-1:0]        en,
    output trig_cfg_t [N-1:0]   cfg,
    output logic [N-1:0]        ack
);
    logic [N-1:0] en_q;
    logic [N-1:0] lvl_q;
    logic [N-1:0] any_q;
    logic [N-1:0] pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            lvl_q <= '0;
            any_q <= '0;
            pol_q <= '0;
        end else if (we) begin
            case (sel)
                RG_EN:   en_q  <= wdata[N-1:0];
                RG_LVL:  lvl_q <= wdata[N-1:0];
                RG_ANY:  any_q <= wdata[N-1:0];
                RG_POL:  pol_q <= wdata[N-1:0];
                default: ;
            endcase
        end
    end

    assign en  = en_q;
    assign ack = (we && sel == RG_ACK) ? wdata[N-1:0] : '0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_cfg
            assign cfg[i] = '{lvl: lvl_q[i], any: any_q[i], pol: pol_q[i]};
        end
    endgenerate
endmodule

// File: rtl/irq_sense_bank.sv
module irq_sense_bank
    import eib_pkg::*;
#(
    parameter int N       = 8,
    parameter int AW      = 5,
    parameter int DW      = 32,
    parameter int SMP_DIV = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  evt_in,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_out
);
    localparam int PAD = DW - N;

    reg_sel_e           sel;
    logic [N-1:0]       synced;
    logic [N-1:0]       cur;
    logic               tick;
    logic [N-1:0]       en;
    logic [N-1:0]       ack;
    logic [N-1:0]       raw;
    logic [N-1:0]       act;
    trig_cfg_t [N-1:0]  cfg;
    logic [N-1:0]       lvl_v, any_v, pol_v;

    assign sel = reg_sel_e'(bus_addr[4:2]);

    eib_sync #(.W(N)) u_sync (
        .clk(clk), .rst(rst), .d_async(evt_in), .d_sync(synced)
    );

    eib_sampler #(.W(N), .SMP_DIV(SMP_DIV)) u_smp (
        .clk(clk), .rst(rst), .in_sync(synced), .tick(tick), .cur(cur)
    );

    eib_regs #(.N(N), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata),
        .en(en), .cfg(cfg), .ack(ack)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_ch
            eib_chan u_ch (
                .clk(clk), .rst(rst), .cfg(cfg[i]), .tick(tick),
                .smp_new(synced[i]), .smp_cur(cur[i]), .clr(ack[i]),
                .raw(raw[i])
            );
            assign lvl_v[i] = cfg[i].lvl;
            assign any_v[i] = cfg[i].any;
            assign pol_v[i] = cfg[i].pol;
        end
    endgenerate

    assign act     = raw & en;
    assign irq_out = |act;

    always_comb begin
        case (sel)
            RG_EN:   bus_rdata = {{PAD{1'b0}}, en};
            RG_RAW:  bus_rdata = {{PAD{1'b0}}, raw};
            RG_ACT:  bus_rdata = {{PAD{1'b0}}, act};
            RG_LVL:  bus_rdata = {{PAD{1'b0}}, lvl_v};
            RG_ANY:  bus_rdata = {{PAD{1'b0}}, any_v};
            RG_POL:  bus_rdata = {{PAD{1'b0}}, pol_v};
            RG_SMP:  bus_rdata = {{PAD{1'b0}}, cur};
            default: bus_rdata = '0;
        endcase
    end

    // R10: nothing enabled means no interrupt
    a_r10_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq_out);

    // R10: a raw event on an enabled line raises the output
    a_r10_enabled_raw_fires: assert property (@(posedge clk) disable iff (rst)
        ((raw & en) != '0) |-> irq_out);

    // R1: first cycle after reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (raw == '0 && en == '0 && !irq_out));
endmodule

// File: tb/sim_irq_sense_bank.sv
module sim_irq_sense_bank;
    localparam int N   = 8;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt_in = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    irq_sense_bank #(.N(N), .AW(5), .DW(32), .SMP_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    // behavioural reference
    logic [7:0] pin_hist[$];
    logic [7:0] m_cur, m_raw, m_en, m_lvl, m_any, m_pol;
    int         m_phase_cnt;
    int         cyc = 0;
    int         n_vec = 0;
    int         n_bad = 0;
    string      phase = "R1 reset";
    int         rot = 0;

    always @(posedge clk) begin
        logic [7:0] s2, clr, nraw;
        bit         strobe;
        cyc <= cyc + 1;
        if (rst) begin
            pin_hist = {8'h00, 8'h00};
            m_cur = 0; m_raw = 0; m_en = 0; m_lvl = 0; m_any = 0; m_pol = 0;
            m_phase_cnt = 0;
        end else begin
            s2     = pin_hist[1];
            strobe = (m_phase_cnt % DIV) == 0;
            clr    = (bus_we && bus_addr[4:2] == 3'd3) ? bus_wdata[7:0] : 8'h00;
            for (int i = 0; i < 8; i++) begin
                bit ed;
                if (m_any[i])      ed = s2[i] != m_cur[i];
                else if (m_pol[i]) ed = s2[i] && !m_cur[i];
                else               ed = !s2[i] && m_cur[i];
                if (m_lvl[i]) nraw[i] = (m_cur[i] == m_pol[i]);
                else          nraw[i] = (strobe && ed) || (m_raw[i] && !clr[i]);
            end
            m_raw = nraw;
            if (strobe) m_cur = s2;
            void'(pin_hist.pop_back());
            pin_hist.push_front(evt_in);
            if (bus_we) begin
                case (bus_addr[4:2])
                    3'd0: m_en  = bus_wdata[7:0];
                    3'd4: m_lvl = bus_wdata[7:0];
                    3'd5: m_any = bus_wdata[7:0];
                    3'd6: m_pol = bus_wdata[7:0];
                    default: ;
                endcase
            end
            m_phase_cnt++;
        end
    end

    function automatic logic [31:0] exp_rd(logic [2:0] s);
        case (s)
            3'd0: return {24'h0, m_en};
            3'd1: return {24'h0, m_raw};
            3'd2: return {24'h0, m_raw & m_en};
            3'd4: return {24'h0, m_lvl};
            3'd5: return {24'h0, m_any};
            3'd6: return {24'h0, m_pol};
            3'd7: return {24'h0, m_cur};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] s);
        case (s)
            3'd0, 3'd4, 3'd5, 3'd6: return "R12";
            3'd1: return "R3/R4/R5/R6/R7/R8/R11";
            3'd2: return "R9";
            3'd3: return "R6";
            default: return "R2";
        endcase
    endfunction

    // compare every cycle, between edges
    always @(negedge clk) begin
        #1;
        if (cyc > 0) begin
            logic [31:0] e;
            logic        ei;
            e  = exp_rd(bus_addr[4:2]);
            ei = |(m_raw & m_en);
            n_vec++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s [%s] addr=%h actual=%h expected=%h",
                         tag_of(bus_addr[4:2]), phase, bus_addr, bus_rdata, e);
            end
            n_vec++;
            if (irq_out !== ei) begin
                n_bad++;
                $display("FAIL R10 [%s] irq actual=%b expected=%b", phase, irq_out, ei);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            bus_we   = 1'b0;
            bus_addr = 5'(rot << 2);
            rot      = (rot + 1) % 8;
        end
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = {s, 2'b00};
        bus_wdata = d;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        logic [15:0] lf;
        // R1: registers and irq during and right after reset
        idle(4);
        @(negedge clk); #1;
        n_vec++;
        if (bus_rdata !== 32'h0 || irq_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset state actual=%h/%b expected=0/0", bus_rdata, irq_out);
        end
        rst = 1'b0;
        idle(8);

        // R12: config registers, upper bits read zero
        phase = "R12 map";
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd6, 32'hABCD_000F);
        idle(10);

        // R3: rising on lines 0-3
        phase = "R3 rising";
        @(negedge clk); evt_in = 8'h0F;
        idle(12);
        // R4: falling on lines 4-7
        phase = "R4 falling";
        @(negedge clk); evt_in = 8'hFF;
        idle(10);
        @(negedge clk); evt_in = 8'h00;
        idle(12);

        // R6: clear, then a zero write
        phase = "R6 clear";
        wr(3'd3, 32'h0000_0033);
        idle(8);
        wr(3'd3, 32'h0);
        idle(8);
        wr(3'd3, 32'hFFFF_FFFF);
        idle(8);

        // R5: any-edge, polarity ignored
        phase = "R5 any edge";
        wr(3'd5, 32'h0000_00F0);
        @(negedge clk); evt_in = 8'hA5;
        idle(10);
        @(negedge clk); evt_in = 8'h5A;
        idle(10);

        // R7: clears racing toggling lines
        phase = "R7 edge vs clear";
        wr(3'd5, 32'hFF);
        for (int k = 0; k < 24; k++) begin
            wr(3'd3, 32'hFF);
            evt_in = ~evt_in;
        end
        idle(10);

        // R8: level sensing, clears ignored while active
        phase = "R8 level";
        wr(3'd4, 32'hFF);
        wr(3'd6, 32'hAA);
        @(negedge clk); evt_in = 8'h0F;
        idle(10);
        wr(3'd3, 32'hFF);
        idle(6);
        @(negedge clk); evt_in = 8'hF0;
        idle(10);

        // R9: partial enable
        phase = "R9 masked";
        wr(3'd0, 32'h55);
        idle(10);
        wr(3'd0, 32'h00);
        idle(6);
        wr(3'd0, 32'hFF);

        // R11: one-cycle pulses vs slow strobe, edge mode
        phase = "R11 short pulse";
        wr(3'd4, 32'h00);
        wr(3'd5, 32'h00);
        wr(3'd6, 32'hFF);
        wr(3'd3, 32'hFF);
        @(negedge clk); evt_in = 8'h00;
        idle(8);
        wr(3'd3, 32'hFF);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); evt_in = 8'h01 << k;
            @(negedge clk); evt_in = 8'h00;
            idle(k % 3);
        end
        idle(8);

        // mixed pseudo-random traffic over all requirements
        phase = "R2/R3/R5/R8 mixed";
        lf = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0: wr(3'd3, {24'h0, lf[15:8]});
                3'd1: wr(3'(lf[5:3]), {lf, lf});
                default: begin
                    @(negedge clk);
                    bus_we = 1'b0;
                    bus_addr = {lf[5:3], 2'b00};
                    evt_in = lf[13:6];
                end
            endcase
        end
        idle(10);
        summary();
    end

    initial begin
        #(4 * 50000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule